// File: doc/BRIEF.md
# Read Return Receiver with Outstanding-Tag Matching

This block sits on the receive side of a 128-bit read-return bus. It watches the request side for read headers that expect data back and keeps their 16-bit tags in a small content-addressable store. When a return header arrives, the block checks its command code, its zero fields and its data-request qualifier. It looks the returned tag up among the outstanding reads, which may come back in any order, and frees the matching entry.

The four cycles after an accepted return header carry the data beats. Each beat is reported with its index, its data and a per-lane even-parity result. The header cycle itself carries no parity and is never checked. In the cycle that reports the fourth beat, a completion strobe gives the tag and the OR of the parity errors from all four beats. Separate one-cycle error strobes flag malformed headers, unknown tags, headers that arrive inside a data window, and read requests that find the tag store full.

Top module: `rd_return_rx`

## Requirements
- R1: After reset every strobe output (beat_vld, cpl_vld, err_hdr, err_unk_tag, err_overlap, err_cam_full) and beat_lane_err are zero.
- R2: A request header with rq_hdr_vld high, bit 126 low and bit 123 high records its tag from bits [79:64] as outstanding. A request with bit 126 high or with rq_hdr_vld low records nothing.
- R3: A return header is well-formed only when bits [127:122] equal 6'b101010, bits [121:82], [63:62] and [55:40] are all zero, and rt_dreq is high. Any other return header pulses err_hdr one cycle later and is discarded: it opens no data window, makes no tag lookup and frees no entry.
- R4: The rt_par value in a header cycle has no effect: a well-formed header is accepted whatever its parity bits are.
- R5: The four cycles after a well-formed header are data beats. Each one is reported one cycle later on beat_vld, with beat_idx counting 0 to 3 and beat_data equal to the bus value.
- R6: On each beat, lane i is bits [32i+31:32i] together with rt_par[i]. beat_lane_err[i] is set when those 33 bits hold an odd number of ones.
- R7: cpl_vld pulses for exactly one cycle, in the same cycle as the report of beat 3. It carries cpl_tag and cpl_par_err, which is the OR of all lane errors over the four beats.
- R8: A return that matches an outstanding tag frees that entry, so a second return of the same tag is unknown.
- R9: A well-formed return whose tag is not outstanding pulses err_unk_tag one cycle after the header. Its beats are still reported, but no cpl_vld follows.
- R10: A return header inside a data window pulses err_overlap one cycle later and abandons the current return without a completion. If that header is well-formed, it starts a fresh window at beat 0.
- R11: Outstanding tags are matched in any order. Each return completes with its own tag, whatever the order of the requests.
- R12: The store holds 16 tags. A read request that arrives while all 16 entries are occupied is dropped and pulses err_cam_full one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rq_hdr_vld | input | 1 | Request-side header valid |
| rq_hdr | input | 128 | Request-side header word |
| rt_hdr_vld | input | 1 | Return-bus header valid |
| rt_dreq | input | 1 | Return header qualifier: data beats follow |
| rt_bus | input | 128 | Return bus: header, then data beats |
| rt_par | input | 4 | Even-parity bit for each 32-bit lane of rt_bus |
| beat_vld | output | 1 | A data beat is reported |
| beat_idx | output | 2 | Index of the reported beat |
| beat_data | output | 128 | Data of the reported beat |
| beat_lane_err | output | 4 | Per-lane parity error of the reported beat |
| cpl_vld | output | 1 | One-cycle completion strobe |
| cpl_tag | output | 16 | Tag of the completed return |
| cpl_par_err | output | 1 | Some lane of some beat of the return failed parity |
| err_hdr | output | 1 | Malformed return header |
| err_unk_tag | output | 1 | Return tag not outstanding |
| err_overlap | output | 1 | Header arrived inside a data window |
| err_cam_full | output | 1 | Read request dropped because the tag store is full |

## Verification
On every cycle, the assertions check the following. Beat indices step by one and complete only at the last beat. A completion never lasts two cycles. A header error and an unknown-tag error never appear together. An overlap error always follows a header on the bus. The tag store gains at most one entry per cycle and stays frozen when it is full and nothing returns. The directed scenarios are the only place the rest can be shown. These are the data and parity values for a given bus pattern, that a tag was really recorded and then consumed, that out-of-order returns pick the right entry, that a malformed header leaves the store untouched, and that an abandoned return never completes.

// File: rtl/rrx_pkg.sv
package rrx_pkg;
  localparam int BUS_W    = 128;
  localparam int TAG_W    = 16;
  localparam int TAG_LSB  = 64;
  localparam int CMD_W    = 6;
  localparam int CMD_LSB  = 122;
  localparam logic [CMD_W-1:0] RET_CMD = 6'b101010;
  // request-side read-with-return decode bits
  localparam int RQ_NOT_BIT = 126;
  localparam int RQ_YES_BIT = 123;

  // true when every must-be-zero field of a return header is clear
  function automatic logic ret_zero_fields_ok(input logic [BUS_W-1:0] h);
    return ~|{h[121:82], h[63:62], h[55:40]};
  endfunction
endpackage

// File: rtl/rrx_hdr_dec.sv
module rrx_hdr_dec
  import rrx_pkg::*;
(
  input  logic             rq_vld,
  input  logic [BUS_W-1:0] rq_word,
  input  logic             rt_vld,
  input  logic             rt_dreq,
  input  logic [BUS_W-1:0] rt_word,
  output logic             rd_req,
  output logic [TAG_W-1:0] rd_tag,
  output logic             ret_ok,
  output logic             ret_bad,
  output logic [TAG_W-1:0] ret_tag
);
  logic cmd_match;

  always_comb begin
    rd_req    = rq_vld & ~rq_word[RQ_NOT_BIT] & rq_word[RQ_YES_BIT];
    rd_tag    = rq_word[TAG_LSB +: TAG_W];
    cmd_match = (rt_word[CMD_LSB +: CMD_W] == RET_CMD);
    ret_ok    = rt_vld & cmd_match & rt_dreq & ret_zero_fields_ok(rt_word);
    ret_bad   = rt_vld & ~ret_ok;
    ret_tag   = rt_word[TAG_LSB +: TAG_W];
  end
endmodule

// File: rtl/rrx_tag_cam.sv
module rrx_tag_cam #(
  parameter int DEPTH = 16,
  parameter int TAG_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ins_en,
  input  logic [TAG_W-1:0] ins_tag,
  input  logic             lk_en,
  input  logic [TAG_W-1:0] lk_tag,
  output logic             lk_hit,
  output logic             full
);
  logic [DEPTH-1:0] vld_q, vld_d;
  logic [DEPTH-1:0] match, hit_sel, free_vec, ins_sel;
  logic [TAG_W-1:0] tag_q [DEPTH];
  logic             ins_go;

  genvar gi;
  generate
    for (gi = 0; gi < DEPTH; gi++) begin : g_ent
      assign match[gi] = vld_q[gi] & (tag_q[gi] == lk_tag);
      always_ff @(posedge clk) begin
        if (ins_go && ins_sel[gi]) tag_q[gi] <= ins_tag;
      end
    end
  endgenerate

  always_comb begin
    free_vec = ~vld_q;
    ins_sel  = free_vec & (~free_vec + DEPTH'(1));
    hit_sel  = match & (~match + DEPTH'(1));
    lk_hit   = |match;
    full     = &vld_q;
    ins_go   = ins_en & ~full;
    vld_d    = vld_q;
    if (lk_en && lk_hit) vld_d = vld_d & ~hit_sel;
    if (ins_go)          vld_d = vld_d | ins_sel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  p_cam_grow_one_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(vld_q) <= $past($countones(vld_q)) + 1);
  p_cam_full_frozen_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !lk_en) |=> $stable(vld_q));
endmodule

// File: rtl/rrx_beat_chk.sv
module rrx_beat_chk #(
  parameter int BEATS  = 4,
  parameter int LANES  = 4,
  parameter int LANE_W = 32,
  parameter int TAG_W  = 16,
  localparam int BUS_W = LANES * LANE_W,
  localparam int CNT_W = (BEATS > 1) ? $clog2(BEATS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hdr_any,
  input  logic             start,
  input  logic [TAG_W-1:0] start_tag,
  input  logic             start_known,
  input  logic [BUS_W-1:0] bus,
  input  logic [LANES-1:0] par,
  output logic             beat_vld,
  output logic [CNT_W-1:0] beat_idx,
  output logic [BUS_W-1:0] beat_data,
  output logic [LANES-1:0] beat_lane_err,
  output logic             cpl_vld,
  output logic [TAG_W-1:0] cpl_tag,
  output logic             cpl_par_err,
  output logic             overlap
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BEATS - 1);

  logic [LANES-1:0] lane_err;
  logic             act_q, act_d, kn_q, kn_d, acc_q, acc_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [TAG_W-1:0] tag_q, tag_d;
  logic             bv_d, cv_d, cperr_d, ov_d;
  logic [CNT_W-1:0] bi_d;
  logic [LANES-1:0] ble_d;

  genvar li;
  generate
    for (li = 0; li < LANES; li++) begin : g_lane
      assign lane_err[li] = ^{bus[li*LANE_W +: LANE_W], par[li]};
    end
  endgenerate

  always_comb begin
    act_d   = act_q;
    cnt_d   = cnt_q;
    acc_d   = acc_q;
    tag_d   = tag_q;
    kn_d    = kn_q;
    bv_d    = 1'b0;
    bi_d    = cnt_q;
    ble_d   = '0;
    cv_d    = 1'b0;
    cperr_d = acc_q | (|lane_err);
    ov_d    = hdr_any & act_q;
    if (start) begin
      act_d = 1'b1;
      cnt_d = '0;
      acc_d = 1'b0;
      tag_d = start_tag;
      kn_d  = start_known;
    end else if (hdr_any) begin
      act_d = 1'b0;
    end else if (act_q) begin
      bv_d  = 1'b1;
      ble_d = lane_err;
      acc_d = acc_q | (|lane_err);
      if (cnt_q == LAST) begin
        act_d = 1'b0;
        cv_d  = kn_q;
      end else begin
        cnt_d = cnt_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q         <= 1'b0;
      cnt_q         <= '0;
      acc_q         <= 1'b0;
      kn_q          <= 1'b0;
      tag_q         <= '0;
      beat_vld      <= 1'b0;
      beat_idx      <= '0;
      beat_lane_err <= '0;
      cpl_vld       <= 1'b0;
      cpl_tag       <= '0;
      cpl_par_err   <= 1'b0;
      overlap       <= 1'b0;
    end else begin
      act_q         <= act_d;
      cnt_q         <= cnt_d;
      acc_q         <= acc_d;
      kn_q          <= kn_d;
      tag_q         <= tag_d;
      beat_vld      <= bv_d;
      beat_idx      <= bi_d;
      beat_lane_err <= ble_d;
      cpl_vld       <= cv_d;
      overlap       <= ov_d;
      if (cv_d) begin
        cpl_tag     <= tag_q;
        cpl_par_err <= cperr_d;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (bv_d) beat_data <= bus;
  end

  p_cpl_on_last_beat_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cpl_vld |-> (beat_vld && beat_idx == LAST));
  p_cpl_one_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cpl_vld |=> !cpl_vld);
  p_beat_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_vld && beat_idx != '0) |-> ($past(beat_vld) && beat_idx == $past(beat_idx) + CNT_W'(1)));
endmodule

// File: rtl/rd_return_rx.sv
module rd_return_rx
  import rrx_pkg::*;
#(
  parameter int TAG_DEPTH = 16,
  parameter int BEATS     = 4,
  parameter int LANES     = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rq_hdr_vld,
  input  logic [127:0] rq_hdr,
  input  logic         rt_hdr_vld,
  input  logic         rt_dreq,
  input  logic [127:0] rt_bus,
  input  logic [3:0]   rt_par,
  output logic         beat_vld,
  output logic [1:0]   beat_idx,
  output logic [127:0] beat_data,
  output logic [3:0]   beat_lane_err,
  output logic         cpl_vld,
  output logic [15:0]  cpl_tag,
  output logic         cpl_par_err,
  output logic         err_hdr,
  output logic         err_unk_tag,
  output logic         err_overlap,
  output logic         err_cam_full
);
  localparam int LANE_W = BUS_W / LANES;

  logic [1:0]       rst_sync;
  logic             rst_q_n;
  logic             rd_req, ret_ok, ret_bad, lk_hit, cam_full;
  logic [TAG_W-1:0] rd_tag, ret_tag;
  logic             err_hdr_d, err_unk_d, err_full_d;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q_n = rst_sync[1];

  rrx_hdr_dec u_dec (
    .rq_vld  (rq_hdr_vld),
    .rq_word (rq_hdr),
    .rt_vld  (rt_hdr_vld),
    .rt_dreq (rt_dreq),
    .rt_word (rt_bus),
    .rd_req  (rd_req),
    .rd_tag  (rd_tag),
    .ret_ok  (ret_ok),
    .ret_bad (ret_bad),
    .ret_tag (ret_tag)
  );

  rrx_tag_cam #(.DEPTH(TAG_DEPTH), .TAG_W(TAG_W)) u_cam (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .ins_en  (rd_req),
    .ins_tag (rd_tag),
    .lk_en   (ret_ok),
    .lk_tag  (ret_tag),
    .lk_hit  (lk_hit),
    .full    (cam_full)
  );

  rrx_beat_chk #(.BEATS(BEATS), .LANES(LANES), .LANE_W(LANE_W), .TAG_W(TAG_W)) u_beat (
    .clk           (clk),
    .rst_n         (rst_q_n),
    .hdr_any       (rt_hdr_vld),
    .start         (ret_ok),
    .start_tag     (ret_tag),
    .start_known   (lk_hit),
    .bus           (rt_bus),
    .par           (rt_par),
    .beat_vld      (beat_vld),
    .beat_idx      (beat_idx),
    .beat_data     (beat_data),
    .beat_lane_err (beat_lane_err),
    .cpl_vld       (cpl_vld),
    .cpl_tag       (cpl_tag),
    .cpl_par_err   (cpl_par_err),
    .overlap       (err_overlap)
  );

  always_comb begin
    err_hdr_d  = ret_bad;
    err_unk_d  = ret_ok & ~lk_hit;
    err_full_d = rd_req & cam_full;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      err_hdr      <= 1'b0;
      err_unk_tag  <= 1'b0;
      err_cam_full <= 1'b0;
    end else begin
      err_hdr      <= err_hdr_d;
      err_unk_tag  <= err_unk_d;
      err_cam_full <= err_full_d;
    end
  end

  p_hdr_unk_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_q_n)
    !(err_hdr && err_unk_tag));
  p_overlap_after_hdr_r10: assert property (@(posedge clk) disable iff (!rst_q_n)
    err_overlap |-> $past(rt_hdr_vld));
  p_unk_no_cpl_r9: assert property (@(posedge clk) disable iff (!rst_q_n)
    err_unk_tag |-> !cpl_vld);
endmodule

// File: tb/rd_return_rx_tb.sv
module rd_return_rx_tb;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         rq_hdr_vld;
  logic [127:0] rq_hdr;
  logic         rt_hdr_vld, rt_dreq;
  logic [127:0] rt_bus;
  logic [3:0]   rt_par;
  logic         beat_vld, cpl_vld, cpl_par_err;
  logic [1:0]   beat_idx;
  logic [127:0] beat_data;
  logic [3:0]   beat_lane_err;
  logic [15:0]  cpl_tag;
  logic         err_hdr, err_unk_tag, err_overlap, err_cam_full;

  int n_checks = 0;
  int n_fail   = 0;

  // results of the last return run
  logic        r_hdr, r_unk, r_ovl, r_cpl, r_perr, r_full;
  logic [15:0] r_tag;

  always #(CLK_PERIOD/2) clk = ~clk;

  rd_return_rx u_dut (
    .clk(clk), .rst_n(rst_n), .rq_hdr_vld(rq_hdr_vld), .rq_hdr(rq_hdr),
    .rt_hdr_vld(rt_hdr_vld), .rt_dreq(rt_dreq), .rt_bus(rt_bus), .rt_par(rt_par),
    .beat_vld(beat_vld), .beat_idx(beat_idx), .beat_data(beat_data),
    .beat_lane_err(beat_lane_err), .cpl_vld(cpl_vld), .cpl_tag(cpl_tag),
    .cpl_par_err(cpl_par_err), .err_hdr(err_hdr), .err_unk_tag(err_unk_tag),
    .err_overlap(err_overlap), .err_cam_full(err_cam_full)
  );

  task automatic chk(input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [127:0] mk_ret(input logic [15:0] tag);
    logic [127:0] h = '0;
    h[127:122] = 6'b101010;
    h[79:64]   = tag;
    h[81:80]   = 2'b11;
    h[61:56]   = 6'h2D;
    h[39:0]    = 40'hA5_C3F0_1E77;
    return h;
  endfunction

  function automatic logic [127:0] mk_rd(input logic [15:0] tag);
    logic [127:0] h = '0;
    h[123]   = 1'b1;
    h[79:64] = tag;
    h[31:0]  = 32'h1357_9BDF;
    return h;
  endfunction

  function automatic logic [127:0] beat_word(input int seed, input int k);
    return {32'hDEAD_0000 ^ 32'(seed * 16 + k), 32'h0F0F_1234 + 32'(k),
            32'(seed) * 32'h0101_0101, 32'hCAFE_0000 | 32'(k * 3 + 1)};
  endfunction

  function automatic logic [3:0] good_par(input logic [127:0] w);
    logic [3:0] p;
    for (int i = 0; i < 4; i++) p[i] = ^w[i*32 +: 32];
    return p;
  endfunction

  task automatic idle();
    rq_hdr_vld = 1'b0; rq_hdr = '0;
    rt_hdr_vld = 1'b0; rt_dreq = 1'b0; rt_bus = '0; rt_par = '0;
  endtask

  task automatic send_req(input logic [127:0] h, input logic v);
    rq_hdr_vld = v; rq_hdr = h;
    @(negedge clk);
    r_full = err_cam_full;
    rq_hdr_vld = 1'b0; rq_hdr = '0;
  endtask

  // drives one header then four bus cycles, checking each beat report
  task automatic run_return(input logic [127:0] hdr, input logic dreq, input logic [3:0] hpar,
                            input int bad_beat, input int bad_lane, input bit exp_beats,
                            input int seed);
    logic [127:0] w;
    logic [3:0]   emask;
    rt_hdr_vld = 1'b1; rt_dreq = dreq; rt_bus = hdr; rt_par = hpar;
    @(negedge clk);
    r_hdr = err_hdr; r_unk = err_unk_tag; r_ovl = err_overlap;
    for (int k = 0; k <= 4; k++) begin
      if (k > 0) begin
        w     = beat_word(seed, k - 1);
        emask = (bad_beat == k - 1) ? (4'b1 << bad_lane) : 4'b0;
        if (exp_beats) begin
          chk("R5", "beat_vld", 128'(beat_vld), 128'(1));
          chk("R5", "beat_idx", 128'(beat_idx), 128'(k - 1));
          chk("R5", "beat_data", beat_data, w);
          chk("R6", "beat_lane_err", 128'(beat_lane_err), 128'(emask));
        end else begin
          chk("R3", "beat_vld after bad header", 128'(beat_vld), 128'(0));
        end
        if (k < 4) chk("R7", "cpl_vld early", 128'(cpl_vld), 128'(0));
      end
      if (k == 4) begin
        r_cpl = cpl_vld; r_tag = cpl_tag; r_perr = cpl_par_err;
      end else begin
        w = beat_word(seed, k);
        rt_hdr_vld = 1'b0; rt_dreq = 1'b0; rt_bus = w;
        rt_par = good_par(w) ^ ((bad_beat == k) ? (4'b1 << bad_lane) : 4'b0);
        @(negedge clk);
      end
    end
    idle();
    @(negedge clk);
    chk("R7", "cpl_vld second cycle", 128'(cpl_vld), 128'(0));
  endtask

  task automatic t_reset();
    chk("R1", "beat_vld", 128'(beat_vld), 128'(0));
    chk("R1", "cpl_vld", 128'(cpl_vld), 128'(0));
    chk("R1", "errors", 128'({err_hdr, err_unk_tag, err_overlap, err_cam_full}), 128'(0));
    chk("R1", "beat_lane_err", 128'(beat_lane_err), 128'(0));
  endtask

  task automatic t_basic();
    send_req(mk_rd(16'h1234), 1'b1);
    chk("R12", "no full on first request", 128'(r_full), 128'(0));
    run_return(mk_ret(16'h1234), 1'b1, 4'b1011, -1, 0, 1, 1);
    chk("R4", "header parity ignored", 128'(r_hdr), 128'(0));
    chk("R2", "recorded tag is known", 128'(r_unk), 128'(0));
    chk("R10", "no overlap", 128'(r_ovl), 128'(0));
    chk("R7", "cpl_vld", 128'(r_cpl), 128'(1));
    chk("R7", "cpl_tag", 128'(r_tag), 128'(16'h1234));
    chk("R7", "cpl_par_err clean", 128'(r_perr), 128'(0));
    run_return(mk_ret(16'h1234), 1'b1, 4'b0000, -1, 0, 1, 2);
    chk("R8", "second return unknown", 128'(r_unk), 128'(1));
    chk("R8", "second return no cpl", 128'(r_cpl), 128'(0));
  endtask

  task automatic t_parity();
    send_req(mk_rd(16'h0042), 1'b1);
    run_return(mk_ret(16'h0042), 1'b1, 4'b0, 2, 3, 1, 3);
    chk("R7", "cpl on parity error", 128'(r_cpl), 128'(1));
    chk("R6", "cpl_par_err beat2 lane3", 128'(r_perr), 128'(1));
    send_req(mk_rd(16'h0043), 1'b1);
    run_return(mk_ret(16'h0043), 1'b1, 4'b0, 0, 0, 1, 4);
    chk("R6", "cpl_par_err beat0 lane0", 128'(r_perr), 128'(1));
    chk("R7", "cpl_tag", 128'(r_tag), 128'(16'h0043));
  endtask

  task automatic t_malformed();
    logic [127:0] h;
    send_req(mk_rd(16'h0077), 1'b1);
    h = mk_ret(16'h0077); h[122] = 1'b1;
    run_return(h, 1'b1, 4'b0, -1, 0, 0, 5);
    chk("R3", "bad command err_hdr", 128'(r_hdr), 128'(1));
    chk("R3", "bad command no lookup", 128'(r_unk), 128'(0));
    chk("R3", "bad command no cpl", 128'(r_cpl), 128'(0));
    h = mk_ret(16'h0077); h[100] = 1'b1;
    run_return(h, 1'b1, 4'b0, -1, 0, 0, 6);
    chk("R3", "field [121:82] nonzero", 128'(r_hdr), 128'(1));
    h = mk_ret(16'h0077); h[62] = 1'b1;
    run_return(h, 1'b1, 4'b0, -1, 0, 0, 7);
    chk("R3", "field [63:62] nonzero", 128'(r_hdr), 128'(1));
    h = mk_ret(16'h0077); h[41] = 1'b1;
    run_return(h, 1'b1, 4'b0, -1, 0, 0, 8);
    chk("R3", "field [55:40] nonzero", 128'(r_hdr), 128'(1));
    run_return(mk_ret(16'h0077), 1'b0, 4'b0, -1, 0, 0, 9);
    chk("R3", "qualifier low", 128'(r_hdr), 128'(1));
    run_return(mk_ret(16'h0077), 1'b1, 4'b0, -1, 0, 1, 10);
    chk("R3", "tag kept after bad headers", 128'(r_cpl), 128'(1));
    chk("R3", "good header no err_hdr", 128'(r_hdr), 128'(0));
  endtask

  task automatic t_ignored_req();
    logic [127:0] h;
    h = mk_rd(16'h0055); h[126] = 1'b1;
    send_req(h, 1'b1);
    send_req(mk_rd(16'h0056), 1'b0);
    run_return(mk_ret(16'h0055), 1'b1, 4'b0, -1, 0, 1, 11);
    chk("R2", "bit126 request not recorded", 128'(r_unk), 128'(1));
    chk("R9", "unknown tag no cpl", 128'(r_cpl), 128'(0));
    run_return(mk_ret(16'h0056), 1'b1, 4'b0, -1, 0, 1, 12);
    chk("R2", "invalid request not recorded", 128'(r_unk), 128'(1));
    chk("R9", "unknown tag no cpl", 128'(r_cpl), 128'(0));
  endtask

  task automatic t_overlap();
    logic [127:0] w;
    send_req(mk_rd(16'h00A1), 1'b1);
    send_req(mk_rd(16'h00A2), 1'b1);
    rt_hdr_vld = 1'b1; rt_dreq = 1'b1; rt_bus = mk_ret(16'h00A1); rt_par = '0;
    @(negedge clk);
    for (int k = 0; k < 2; k++) begin
      w = beat_word(20, k);
      rt_hdr_vld = 1'b0; rt_dreq = 1'b0; rt_bus = w; rt_par = good_par(w);
      @(negedge clk);
    end
    run_return(mk_ret(16'h00A2), 1'b1, 4'b0, -1, 0, 1, 13);
    chk("R10", "err_overlap", 128'(r_ovl), 128'(1));
    chk("R10", "restarted return completes", 128'(r_cpl), 128'(1));
    chk("R10", "completed tag is new one", 128'(r_tag), 128'(16'h00A2));
    run_return(mk_ret(16'h00A1), 1'b1, 4'b0, -1, 0, 1, 14);
    chk("R10", "abandoned tag consumed", 128'(r_unk), 128'(1));
  endtask

  task automatic t_full_ooo();
    for (int i = 0; i < 16; i++) begin
      send_req(mk_rd(16'h0300 + 16'(i)), 1'b1);
      chk("R12", "fill without full error", 128'(r_full), 128'(0));
    end
    send_req(mk_rd(16'h03FF), 1'b1);
    chk("R12", "17th request full error", 128'(r_full), 128'(1));
    run_return(mk_ret(16'h03FF), 1'b1, 4'b0, -1, 0, 1, 15);
    chk("R12", "dropped tag unknown", 128'(r_unk), 128'(1));
    for (int i = 15; i >= 0; i--) begin
      run_return(mk_ret(16'h0300 + 16'(i)), 1'b1, 4'b0, -1, 0, 1, 30 + i);
      chk("R11", "out-of-order cpl", 128'(r_cpl), 128'(1));
      chk("R11", "out-of-order tag", 128'(r_tag), 128'(16'h0300 + 16'(i)));
    end
    send_req(mk_rd(16'h03FF), 1'b1);
    chk("R12", "space after drain", 128'(r_full), 128'(0));
    run_return(mk_ret(16'h03FF), 1'b1, 4'b0, -1, 0, 1, 16);
    chk("R12", "request after drain completes", 128'(r_cpl), 128'(1));
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    idle();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_basic();
    t_parity();
    t_malformed();
    t_ignored_req();
    t_overlap();
    t_full_ooo();
    repeat (2) @(negedge clk);
    $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule